// File: doc/BRIEF.md
# Timed Wake-Up Sequence Validator

This block watches a stream of already-decoded back-channel symbols, each tagged with the timestamp of the advertising event that carried it. It compares the stream against a programmed ordered pattern of one to eight symbol IDs. It also requires that consecutive accepted symbols be spaced like legal advertising events: at least 20 ms apart, and no more than the 10.24 s base interval plus the 10 ms random extra delay, so 10.25 s in total. When the last pattern entry is matched with legal spacing, a one-clock wake pulse is raised.

Timestamps and the current time come in as tick counts from an outside timebase. The default tick is 100 µs, so 20 ms is 200 ticks and 10.25 s is 102500 ticks. Gaps are taken modulo the timestamp width, so the timebase may wrap. After a wake, the validator locks and ignores symbols until the `clear` input is asserted.

Top module: `wake_seq_validator`

## Requirements
- R1: After synchronous reset, `step` is 0, `wake` is 0 and `locked` is 0.
- R2: With `step` at 0, a symbol equal to pattern entry 0 (bits `[SYM_W-1:0]` of `pat_syms`) moves `step` to 1 whatever its timestamp; any other symbol leaves `step` at 0.
- R3: With `step` at k>0, a symbol equal to entry k (bits `[k*SYM_W +: SYM_W]`) whose gap from the last accepted timestamp is within 200..102500 ticks inclusive moves `step` to k+1.
- R4: A gap below 200 ticks or above 102500 ticks sets `step` to 1 if the symbol equals entry 0, and to 0 otherwise.
- R5: A symbol other than entry k at step k>0 sets `step` to 1 if it equals entry 0, and to 0 otherwise.
- R6: When the accepted symbol completes the pattern, `wake` is 1 for exactly one clock, `step` returns to 0 and `locked` becomes 1, all in the cycle after the symbol.
- R7: The effective pattern length is `pat_len` clamped to 1..8: a value of 0 acts as 1, and values above 8 act as 8. With length 1, the first match wakes at once.
- R8: With `step` nonzero, no symbol offered and `time_now` more than 102500 ticks past the last accepted timestamp, `step` returns to 0 on the next clock.
- R9: While `locked`, symbols change neither `step` nor `wake`. `clear` drops `locked` and zeroes `step`, and it wins over a symbol offered in the same cycle.
- R10: Timestamp gaps are computed modulo 2^TS_W, so a gap across counter wrap is judged by its true length.
- R11: When the timeout condition and a symbol fall in the same cycle, the symbol's outcome under R3 to R5 decides the next `step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Releases the post-wake lock and zeroes progress |
| sym_valid | input | 1 | One-cycle strobe: a decoded symbol is offered |
| sym_id | input | SYM_W | Decoded symbol ID |
| sym_ts | input | TS_W | Event timestamp of the offered symbol, in ticks |
| time_now | input | TS_W | Current time from the shared timebase, in ticks |
| pat_len | input | LEN_W | Programmed pattern length (clamped to 1..MAX_LEN) |
| pat_syms | input | MAX_LEN*SYM_W | Pattern entries, entry i at bits [i*SYM_W +: SYM_W] |
| wake | output | 1 | One-clock wake pulse |
| step | output | LEN_W | Number of pattern entries matched so far |
| locked | output | 1 | High after a wake until cleared |

## Verification
The silence timeout and a symbol arrival can land in the same cycle. This can happen when a symbol's timestamp lags the current time. The bench provokes it by offering a symbol whose own gap is legal while `time_now` is already more than 10.25 s past the last accepted timestamp. It then expects `step` to advance, not to drop to idle. A second collision, `clear` together with a symbol while locked, is judged by `step` staying at 0 and `locked` falling.

// File: rtl/wsv_pkg.sv
package wsv_pkg;

    // Default timing limits, in microseconds
    localparam int unsigned MIN_GAP_US  = 20_000;
    localparam int unsigned BASE_MAX_US = 10_240_000;
    localparam int unsigned JITTER_US   = 10_000;

    // What a single offered symbol does to progress
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,   // idle and not the first entry
        ACT_ADVANCE = 2'd1,   // expected entry with legal spacing
        ACT_RESTART = 2'd2,   // restart progress at step 1
        ACT_DROP    = 2'd3    // return to idle
    } act_e;

    typedef struct packed {
        logic hit_next;   // equals entry at current step
        logic hit_first;  // equals entry 0
        logic gap_ok;     // spacing from last accepted event is legal
    } cmp_t;

    function automatic act_e decide(input cmp_t c, input logic at_idle);
        act_e a;
        if (at_idle)
            a = c.hit_first ? ACT_RESTART : ACT_HOLD;
        else if (c.hit_next && c.gap_ok)
            a = ACT_ADVANCE;
        else if (c.hit_first)
            a = ACT_RESTART;
        else
            a = ACT_DROP;
        return a;
    endfunction

endpackage

// File: rtl/wsv_pattern_sel.sv
module wsv_pattern_sel #(
    parameter int SYM_W   = 4,
    parameter int MAX_LEN = 8,
    parameter int IDX_W   = 4
) (
    input  logic [MAX_LEN*SYM_W-1:0] pat_syms,
    input  logic [IDX_W-1:0]         idx,
    output logic [SYM_W-1:0]         ent_cur,
    output logic [SYM_W-1:0]         ent_first
);

    logic [SYM_W-1:0] ent [MAX_LEN];

    generate
        for (genvar g = 0; g < MAX_LEN; g++) begin : g_unpack
            assign ent[g] = pat_syms[g*SYM_W +: SYM_W];
        end
    endgenerate

    assign ent_first = ent[0];

    always_comb begin
        ent_cur = ent[0];
        for (int i = 0; i < MAX_LEN; i++) begin
            if (idx == IDX_W'(i))
                ent_cur = ent[i];
        end
    end

endmodule

// File: rtl/wsv_gap_check.sv
module wsv_gap_check #(
    parameter int          TS_W    = 24,
    parameter int unsigned MIN_GAP = 200,
    parameter int unsigned MAX_GAP = 102_500
) (
    input  logic [TS_W-1:0] ts_new,
    input  logic [TS_W-1:0] ts_ref,
    input  logic [TS_W-1:0] now,
    output logic            gap_ok,
    output logic            expired
);

    localparam logic [TS_W-1:0] LO = TS_W'(MIN_GAP);
    localparam logic [TS_W-1:0] HI = TS_W'(MAX_GAP);

    logic [TS_W-1:0] gap;
    logic [TS_W-1:0] elapsed;

    // Modulo subtraction keeps wrap-around gaps correct
    assign gap     = ts_new - ts_ref;
    assign elapsed = now - ts_ref;

    assign gap_ok  = (gap >= LO) && (gap <= HI);
    assign expired = (elapsed > HI);

endmodule

// File: rtl/wsv_seq_fsm.sv
module wsv_seq_fsm
    import wsv_pkg::*;
#(
    parameter int SYM_W = 4,
    parameter int TS_W  = 24,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_id,
    input  logic [TS_W-1:0]  sym_ts,
    input  logic [IDX_W-1:0] len_eff,
    input  logic [SYM_W-1:0] ent_cur,
    input  logic [SYM_W-1:0] ent_first,
    input  logic             gap_ok,
    input  logic             expired,
    output logic [IDX_W-1:0] step,
    output logic [TS_W-1:0]  last_ts,
    output logic             wake,
    output logic             locked
);

    cmp_t             cmp;
    act_e             act;
    logic [IDX_W-1:0] next_idx;
    logic             done;

    always_comb begin
        cmp.hit_next  = (sym_id == ent_cur);
        cmp.hit_first = (sym_id == ent_first);
        cmp.gap_ok    = gap_ok;
        act           = decide(cmp, step == '0);
        next_idx      = (act == ACT_ADVANCE) ? step + 1'b1 : IDX_W'(1);
        done          = ((act == ACT_ADVANCE) || (act == ACT_RESTART))
                        && (next_idx == len_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            last_ts <= '0;
            wake    <= 1'b0;
            locked  <= 1'b0;
        end else begin
            wake <= 1'b0;
            if (clear) begin
                locked <= 1'b0;
                step   <= '0;
            end else if (!locked && sym_valid) begin
                unique case (act)
                    ACT_ADVANCE, ACT_RESTART: begin
                        last_ts <= sym_ts;
                        if (done) begin
                            step   <= '0;
                            wake   <= 1'b1;
                            locked <= 1'b1;
                        end else begin
                            step <= next_idx;
                        end
                    end
                    ACT_DROP: step <= '0;
                    default:  step <= step;
                endcase
            end else if (!locked && (step != '0) && expired) begin
                step <= '0;
            end
        end
    end

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake); // R6

    AST_WAKE_LOCKS: assert property (@(posedge clk) disable iff (rst)
        wake |-> (locked && step == '0)); // R6

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        step < len_eff); // R7

    AST_STEP_CLIMB: assert property (@(posedge clk) disable iff (rst)
        (step != '0) |=> (step <= $past(step) + 1'b1)); // R3

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (locked && !clear) |=> (locked && step == '0 && !wake)); // R9

    AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!locked && step == '0)); // R9

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (step != '0 && expired && !sym_valid && !clear) |=> (step == '0)); // R8

endmodule

// File: rtl/wake_seq_validator.sv
module wake_seq_validator
    import wsv_pkg::*;
#(
    parameter int SYM_W   = 4,
    parameter int MAX_LEN = 8,
    parameter int TS_W    = 24,
    parameter int TICK_US = 100,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     sym_valid,
    input  logic [SYM_W-1:0]         sym_id,
    input  logic [TS_W-1:0]          sym_ts,
    input  logic [TS_W-1:0]          time_now,
    input  logic [LEN_W-1:0]         pat_len,
    input  logic [MAX_LEN*SYM_W-1:0] pat_syms,
    output logic                     wake,
    output logic [LEN_W-1:0]         step,
    output logic                     locked
);

    localparam int unsigned MIN_GAP = MIN_GAP_US / TICK_US;
    localparam int unsigned MAX_GAP = (BASE_MAX_US + JITTER_US) / TICK_US;

    logic [LEN_W-1:0] len_eff;
    logic [SYM_W-1:0] ent_cur;
    logic [SYM_W-1:0] ent_first;
    logic [TS_W-1:0]  last_ts;
    logic             gap_ok;
    logic             expired;

    always_comb begin
        if (pat_len == '0)
            len_eff = LEN_W'(1);
        else if (pat_len > LEN_W'(MAX_LEN))
            len_eff = LEN_W'(MAX_LEN);
        else
            len_eff = pat_len;
    end

    wsv_pattern_sel #(
        .SYM_W   (SYM_W),
        .MAX_LEN (MAX_LEN),
        .IDX_W   (LEN_W)
    ) u_sel (
        .pat_syms  (pat_syms),
        .idx       (step),
        .ent_cur   (ent_cur),
        .ent_first (ent_first)
    );

    wsv_gap_check #(
        .TS_W    (TS_W),
        .MIN_GAP (MIN_GAP),
        .MAX_GAP (MAX_GAP)
    ) u_gap (
        .ts_new  (sym_ts),
        .ts_ref  (last_ts),
        .now     (time_now),
        .gap_ok  (gap_ok),
        .expired (expired)
    );

    wsv_seq_fsm #(
        .SYM_W (SYM_W),
        .TS_W  (TS_W),
        .IDX_W (LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .sym_valid (sym_valid),
        .sym_id    (sym_id),
        .sym_ts    (sym_ts),
        .len_eff   (len_eff),
        .ent_cur   (ent_cur),
        .ent_first (ent_first),
        .gap_ok    (gap_ok),
        .expired   (expired),
        .step      (step),
        .last_ts   (last_ts),
        .wake      (wake),
        .locked    (locked)
    );

endmodule

// File: tb/sim_wake_seq_validator.sv
module sim_wake_seq_validator;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    logic        clk = 1'b0;
    logic        rst, clear, sym_valid;
    logic [3:0]  sym_id, pat_len;
    logic [23:0] sym_ts, time_now;
    logic [31:0] pat_syms;
    logic        wake, locked;
    logic [3:0]  step;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_seq_validator u0 (
        .clk(clk), .rst(rst), .clear(clear), .sym_valid(sym_valid),
        .sym_id(sym_id), .sym_ts(sym_ts), .time_now(time_now),
        .pat_len(pat_len), .pat_syms(pat_syms),
        .wake(wake), .step(step), .locked(locked)
    );

    // Row: clr, vld, sym, ts, now, exp step, exp wake, exp locked
    // Pattern entries 0..3 = 3,5,7,9; gap limits 200..102500 ticks
    localparam logic [59:0] VEC [0:NV-1] = '{
        {1'b0,1'b1,4'd9,24'd500,     24'd500,     4'd0,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd1000,    24'd1000,    4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd5,24'd1200,    24'd1200,    4'd2,1'b0,1'b0},
        {1'b0,1'b1,4'd7,24'd1399,    24'd1399,    4'd0,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd2000,    24'd2000,    4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd4,24'd3000,    24'd3000,    4'd0,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd4000,    24'd4000,    4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd5000,    24'd5000,    4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd5,24'd107500,  24'd107500,  4'd2,1'b0,1'b0},
        {1'b0,1'b1,4'd7,24'd210001,  24'd210001,  4'd0,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd300000,  24'd300000,  4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd5,24'd300300,  24'd300300,  4'd2,1'b0,1'b0},
        {1'b0,1'b1,4'd7,24'd300600,  24'd300600,  4'd3,1'b0,1'b0},
        {1'b0,1'b1,4'd9,24'd300900,  24'd300900,  4'd0,1'b1,1'b1},
        {1'b0,1'b0,4'd0,24'd300900,  24'd300900,  4'd0,1'b0,1'b1},
        {1'b0,1'b1,4'd3,24'd301200,  24'd301200,  4'd0,1'b0,1'b1},
        {1'b1,1'b1,4'd3,24'd301500,  24'd301500,  4'd0,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd302000,  24'd302000,  4'd1,1'b0,1'b0},
        {1'b0,1'b0,4'd0,24'd0,       24'd404500,  4'd1,1'b0,1'b0},
        {1'b0,1'b0,4'd0,24'd0,       24'd404501,  4'd0,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd500000,  24'd500000,  4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd3,24'd16777000,24'd16777000,4'd1,1'b0,1'b0},
        {1'b0,1'b1,4'd5,24'd100,     24'd100,     4'd2,1'b0,1'b0},
        {1'b0,1'b1,4'd7,24'd300,     24'd102601,  4'd3,1'b0,1'b0},
        {1'b0,1'b1,4'd9,24'd500,     24'd500,     4'd0,1'b1,1'b1}
    };

    localparam string TAG [0:NV-1] = '{
        "R2", "R2", "R3", "R4", "R2", "R5", "R2", "R5", "R3", "R4",
        "R2", "R3", "R3", "R6", "R6", "R9", "R9", "R2", "R8", "R8",
        "R2", "R4", "R10", "R11", "R6"
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic v, input logic [3:0] s,
                         input logic [23:0] ts, input logic [23:0] nw);
        @(negedge clk);
        clear = c; sym_valid = v; sym_id = s; sym_ts = ts; time_now = nw;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; clear = 1'b0; sym_valid = 1'b0; sym_id = '0;
        sym_ts = '0; time_now = '0; pat_len = 4'd4;
        pat_syms = 32'h0000_9753;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "step",   step,   0);
        check("R1", "wake",   wake,   0);
        check("R1", "locked", locked, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][59], VEC[i][58], VEC[i][57:54],
                  VEC[i][53:30], VEC[i][29:6]);
            check(TAG[i], "step",   step,   int'(VEC[i][5:2]));
            check(TAG[i], "wake",   wake,   int'(VEC[i][1]));
            check(TAG[i], "locked", locked, int'(VEC[i][0]));
        end

        // R6: wake lasts one clock only
        drive(1'b0, 1'b0, 4'd0, 24'd500, 24'd500);
        check("R6", "wake after pulse", wake, 0);

        // R1: reset in the middle of progress
        drive(1'b1, 1'b0, 4'd0, 24'd600, 24'd600);
        drive(1'b0, 1'b1, 4'd3, 24'd1000, 24'd1000);
        check("R2", "step", step, 1);
        @(negedge clk);
        rst = 1'b1; sym_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "step mid reset", step, 0);
        check("R1", "locked mid reset", locked, 0);
        @(negedge clk);
        rst = 1'b0;

        // R7: length 0 acts as 1, first match wakes at once
        pat_len = 4'd0;
        drive(1'b0, 1'b1, 4'd3, 24'd2000, 24'd2000);
        check("R7", "wake len0", wake, 1);
        check("R7", "locked len0", locked, 1);

        // R7: length above 8 acts as 8; seven matches leave step at 7
        drive(1'b1, 1'b0, 4'd0, 24'd2000, 24'd2000);
        pat_len = 4'd12;
        pat_syms = 32'h1234_5678;
        for (int k = 0; k < 7; k++)
            drive(1'b0, 1'b1, pat_syms[k*4 +: 4], 24'(3000 + k*300),
                  24'(3000 + k*300));
        check("R7", "step len clamp", step, 7);
        check("R7", "no early wake", wake, 0);
        drive(1'b0, 1'b1, 4'd1, 24'd5100, 24'd5100);
        check("R7", "wake at 8", wake, 1);

        finish_run();
    end

endmodule